// File: doc/BRIEF.md
# Bus-Mapped Serial Port with Bit Set/Clear Aliases

This block is a serial transmitter and receiver that a processor drives through a small 32-bit register window. Software writes bytes into a transmit queue and takes received bytes out of a receive queue. It programs the bit rate with one divider register, and it controls the line through a mode register and a control/status register. Every frame has one start bit, eight data bits sent least significant bit first, and one stop bit. The frame has no parity bit.

The mode and control/status registers each have two extra write-only addresses. The first address clears the bits that are 1 in the written word. The second address sets those bits. Software can therefore change one control bit without a read-modify-write sequence. A receive overrun is sticky: it blocks any further reception until software clears it. A break request holds the line low for one whole frame time and then clears itself.

Top module: `mmio_uart`

## Requirements
- R1: After reset the mode register reads 0x0, the control/status register reads 0x100 (only the transmit-empty flag set), and the serial output is high.
- R2: Plain register addresses are: mode 0x00, control/status 0x10, transmit data 0x20, receive data 0x30, divider 0x40. Mode bit 15 is the module enable. Control/status bits: 12 receive enable, 11 break request, 10 transmit enable, 9 transmit queue full (read-only), 8 transmitter empty (read-only), 1 overrun, 0 receive data ready (read-only). Other bits read 0, and the divider reads back its low 16 bits.
- R3: A write to register base +0x4 clears the bits that are 1 in the data. A write to base +0x8 sets those bits. Other bits keep their value, and a read of either alias returns 0.
- R4: While mode bit 15 is 0, the serial output stays high and queued bytes are not sent.
- R5: A frame is a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts 16 × (divider + 1) clock cycles.
- R6: The transmit queue holds 4 bytes and raises bit 9 when it is full. A data write while it is full is dropped. Bit 8 is 1 only when the queue is empty and no frame or break is on the line.
- R7: A received byte sets bit 0. A read of 0x30 returns the oldest byte in bits 7:0 and removes it from the queue.
- R8: A byte that completes while the 4-entry receive queue is full sets bit 1. Bit 1 stays set, and no byte is accepted, until software clears bit 1 through 0x14. Reception then resumes.
- R9: Setting bit 11 makes the line go low for 10 bit times once the current frame ends, ahead of any queued byte. Bit 11 then returns to 0 by itself.
- R10: The receiver samples 16 times per bit. It drops a start edge whose line is high again at the eighth sample, and it takes each data bit at mid-bit.
- R11: While bit 12 is 0, incoming frames are ignored and bit 0 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read; pops the receive queue at 0x30 |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, resynchronised internally |

## Verification
The assertions assume that each strobe lasts one cycle per access and that a read of 0x30 happens only while bit 0 is set. They also assume that the serial input only changes on bit boundaries measured at the programmed rate. The bench follows all of these rules: it drives the bus at the falling clock edge with single-cycle strobes, pops only bytes it has already seen flagged, and generates incoming frames at exactly 16 × (divider + 1) clocks per bit. Its one deliberate exception is a short low pulse on the serial input, which exercises start-bit rejection.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_TXD  = 8'h20;
  localparam logic [7:0] OFS_RXD  = 8'h30;
  localparam logic [7:0] OFS_BAUD = 8'h40;
  localparam logic [7:0] ALIAS_CLR = 8'h04;
  localparam logic [7:0] ALIAS_SET = 8'h08;

  localparam int B_MODE_EN = 15;
  localparam int B_RX_EN   = 12;
  localparam int B_BRK     = 11;
  localparam int B_TX_EN   = 10;
  localparam int B_TX_FULL = 9;
  localparam int B_TX_MT   = 8;
  localparam int B_OVR     = 1;
  localparam int B_RX_RDY  = 0;

  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;

  typedef enum logic [1:0] {WK_NONE, WK_PLAIN, WK_CLR, WK_SET} wkind_t;

  function automatic logic apply_bit(input logic cur, input logic wbit, input wkind_t k);
    case (k)
      WK_PLAIN: apply_bit = wbit;
      WK_CLR:   apply_bit = cur & ~wbit;
      WK_SET:   apply_bit = cur | wbit;
      default:  apply_bit = cur;
    endcase
  endfunction
endpackage

// File: rtl/mu_fifo.sv
module mu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   level
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [AW:0]   lvl_q, lvl_n;
  logic push_ok, pop_ok;

  assign full    = (lvl_q == (AW+1)'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign level   = lvl_q;
  assign dout    = mem[rptr_q];
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    lvl_n  = lvl_q;
    if (push_ok) wptr_n = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   lvl_n = lvl_q + 1'b1;
      2'b01:   lvl_n = lvl_q - 1'b1;
      default: lvl_n = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= (AW+1)'(DEPTH)); // R6
  AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (lvl_q == (AW+1)'(DEPTH))); // R6
endmodule

// File: rtl/mu_tx.sv
module mu_tx
  import mmio_uart_pkg::*;
#(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_en,
  input  logic [BAUD_W-1:0] baud,
  input  logic              have_data,
  input  logic [7:0]        data,
  input  logic              brk_req,
  output logic              take,
  output logic              brk_done,
  output logic              busy,
  output logic              line
);
  localparam int CW = BAUD_W + 4;
  typedef enum logic [1:0] {T_IDLE, T_FRAME, T_BREAK} tstate_t;

  tstate_t st_q, st_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [3:0]    bit_q, bit_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] bit_len;

  assign bit_len = {baud, 4'hF};
  assign busy    = (st_q != T_IDLE);
  assign line    = (st_q == T_IDLE) ? 1'b1 : sh_q[0];

  always_comb begin
    st_n = st_q; sh_n = sh_q; bit_n = bit_q; cnt_n = cnt_q;
    take = 1'b0; brk_done = 1'b0;
    if (!en) begin
      st_n = T_IDLE; cnt_n = '0; bit_n = '0;
    end else if (st_q == T_IDLE) begin
      cnt_n = '0; bit_n = '0;
      if (brk_req) begin
        st_n = T_BREAK; sh_n = '0;
      end else if (tx_en && have_data) begin
        st_n = T_FRAME; sh_n = {1'b1, data, 1'b0}; take = 1'b1;
      end
    end else if (cnt_q == bit_len) begin
      cnt_n = '0;
      if (st_q == T_FRAME) sh_n = {1'b1, sh_q[FRAME_BITS-1:1]};
      if (bit_q == 4'(FRAME_BITS-1)) begin
        st_n = T_IDLE;
        brk_done = (st_q == T_BREAK);
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= T_IDLE; sh_q <= '1; bit_q <= '0; cnt_q <= '0;
    end else begin
      st_q <= st_n; sh_q <= sh_n; bit_q <= bit_n; cnt_q <= cnt_n;
    end
  end

  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_BREAK) |-> !line); // R9
  AST_TAKE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (st_q == T_FRAME)); // R5
endmodule

// File: rtl/mu_rx.sv
module mu_rx
  import mmio_uart_pkg::*;
#(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BAUD_W-1:0] baud,
  input  logic              rxd_s,
  output logic              valid,
  output logic [7:0]        data
);
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rstate_t;

  rstate_t st_q, st_n;
  logic [BAUD_W-1:0] pre_q, pre_n;
  logic [3:0] os_q, os_n;
  logic [2:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic       val_q, val_n;
  logic       tick;

  assign tick  = (pre_q == baud);
  assign valid = val_q;
  assign data  = sh_q;

  always_comb begin
    st_n = st_q; pre_n = pre_q; os_n = os_q; bit_n = bit_q; sh_n = sh_q; val_n = 1'b0;
    if (!en) begin
      st_n = R_IDLE; pre_n = '0; os_n = '0; bit_n = '0;
    end else begin
      pre_n = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        case (st_q)
          R_IDLE: if (!rxd_s) begin st_n = R_START; os_n = '0; end
          R_START: begin
            if (os_q == 4'd7) begin
              os_n = '0; bit_n = '0;
              st_n = rxd_s ? R_IDLE : R_DATA;
            end else os_n = os_q + 1'b1;
          end
          R_DATA: begin
            if (os_q == 4'd15) begin
              os_n = '0;
              sh_n = {rxd_s, sh_q[7:1]};
              if (bit_q == 3'(DATA_BITS-1)) st_n = R_STOP;
              else bit_n = bit_q + 1'b1;
            end else os_n = os_q + 1'b1;
          end
          default: begin
            if (os_q == 4'd15) begin
              st_n = R_IDLE; val_n = rxd_s;
            end else os_n = os_q + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= R_IDLE; pre_q <= '0; os_q <= '0; bit_q <= '0; sh_q <= '0; val_q <= 1'b0;
    end else begin
      st_q <= st_n; pre_q <= pre_n; os_q <= os_n; bit_q <= bit_n; sh_q <= sh_n; val_q <= val_n;
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R7
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid); // R11
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int BAUD_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd
);
  localparam int LW = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
  localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(OFS_BAUD);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ALIAS_CLR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ALIAS_SET);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic [1:0] rxd_sync_q;

  logic mode_q, mode_n, rxen_q, rxen_n, brk_q, brk_n, txen_q, txen_n, ovr_q, ovr_n;
  logic [BAUD_W-1:0] baud_q, baud_n;
  wkind_t mode_k, stat_k;

  logic tx_wr, tx_take, tx_full, tx_empty, tx_busy, tx_line, brk_done;
  logic [7:0] tx_head;
  logic [LW-1:0] tx_level;
  logic rx_valid, rx_push, rx_pop, rx_full, rx_empty, ovr_hit;
  logic [7:0] rx_byte, rx_head;
  logic [LW-1:0] rx_level;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[14:13], bus_wdata[9:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rxd_sync_q <= 2'b11;
    else        rxd_sync_q <= {rxd_sync_q[0], rxd};
  end

  always_comb begin
    mode_k = WK_NONE;
    stat_k = WK_NONE;
    if (bus_wr) begin
      if      (bus_addr == A_MODE)         mode_k = WK_PLAIN;
      else if (bus_addr == (A_MODE|A_CLR)) mode_k = WK_CLR;
      else if (bus_addr == (A_MODE|A_SET)) mode_k = WK_SET;
      if      (bus_addr == A_STAT)         stat_k = WK_PLAIN;
      else if (bus_addr == (A_STAT|A_CLR)) stat_k = WK_CLR;
      else if (bus_addr == (A_STAT|A_SET)) stat_k = WK_SET;
    end
  end

  assign tx_wr   = bus_wr & (bus_addr == A_TXD);
  assign rx_pop  = bus_rd & (bus_addr == A_RXD);
  assign rx_push = rx_valid & ~ovr_q & ~rx_full;
  assign ovr_hit = rx_valid & ~ovr_q & rx_full;

  always_comb begin
    mode_n = apply_bit(mode_q, bus_wdata[B_MODE_EN], mode_k);
    rxen_n = apply_bit(rxen_q, bus_wdata[B_RX_EN], stat_k);
    brk_n  = apply_bit(brk_q,  bus_wdata[B_BRK],   stat_k);
    txen_n = apply_bit(txen_q, bus_wdata[B_TX_EN], stat_k);
    ovr_n  = apply_bit(ovr_q,  bus_wdata[B_OVR],   stat_k);
    baud_n = (bus_wr && bus_addr == A_BAUD) ? bus_wdata[BAUD_W-1:0] : baud_q;
    if (brk_done) brk_n = 1'b0;
    if (ovr_hit)  ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q <= 1'b0; rxen_q <= 1'b0; brk_q <= 1'b0; txen_q <= 1'b0; ovr_q <= 1'b0;
      baud_q <= '0;
    end else begin
      mode_q <= mode_n; rxen_q <= rxen_n; brk_q <= brk_n; txen_q <= txen_n; ovr_q <= ovr_n;
      baud_q <= baud_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_MODE) begin
        bus_rdata[B_MODE_EN] = mode_q;
      end else if (bus_addr == A_STAT) begin
        bus_rdata[B_RX_EN]   = rxen_q;
        bus_rdata[B_BRK]     = brk_q;
        bus_rdata[B_TX_EN]   = txen_q;
        bus_rdata[B_TX_FULL] = tx_full;
        bus_rdata[B_TX_MT]   = tx_empty & ~tx_busy;
        bus_rdata[B_OVR]     = ovr_q;
        bus_rdata[B_RX_RDY]  = ~rx_empty;
      end else if (bus_addr == A_RXD) begin
        bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      end else if (bus_addr == A_BAUD) begin
        bus_rdata[BAUD_W-1:0] = baud_q;
      end
    end
  end

  mu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .push(tx_wr), .din(bus_wdata[7:0]), .pop(tx_take),
    .dout(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level));

  mu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .dout(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level));

  mu_tx #(.BAUD_W(BAUD_W)) u_tx (
    .clk(clk), .rst_n(rst_i), .en(mode_q), .tx_en(txen_q), .baud(baud_q),
    .have_data(~tx_empty), .data(tx_head), .brk_req(brk_q),
    .take(tx_take), .brk_done(brk_done), .busy(tx_busy), .line(tx_line));

  mu_rx #(.BAUD_W(BAUD_W)) u_rx (
    .clk(clk), .rst_n(rst_i), .en(mode_q & rxen_q), .baud(baud_q),
    .rxd_s(rxd_sync_q[1]), .valid(rx_valid), .data(rx_byte));

  assign txd = mode_q ? tx_line : 1'b1;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    (ovr_q && !(bus_wr && (bus_addr == A_STAT || bus_addr == (A_STAT|A_CLR)))) |=> ovr_q); // R8
  AST_OVR_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_i)
    (ovr_q && !rx_pop) |=> $stable(rx_level)); // R8
  AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_full && tx_wr && !tx_take) |=> $stable(tx_level)); // R6
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_empty && !tx_busy) |-> txd); // R6
  AST_BRK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_i)
    brk_done |=> !brk_q); // R9
endmodule

// File: tb/sim_mmio_uart.sv
`timescale 1ns/1ps
module sim_mmio_uart;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        txd;
  logic        rxd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mmio_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {is_write, address, write data, expected read data}
  localparam int NV = 24;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h40, 32'h0000_1234, 32'h0},
    {1'b0, 8'h40, 32'h0,         32'h0000_1234},
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0000_8000},
    {1'b1, 8'h04, 32'h0000_8000, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0},
    {1'b1, 8'h08, 32'h0000_8000, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0000_8000},
    {1'b0, 8'h08, 32'h0,         32'h0},
    {1'b0, 8'h04, 32'h0,         32'h0},
    {1'b1, 8'h04, 32'h0000_8000, 32'h0},
    {1'b1, 8'h18, 32'h0000_1400, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_1500},
    {1'b1, 8'h14, 32'h0000_0400, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_1100},
    {1'b1, 8'h18, 32'h0000_0002, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_1102},
    {1'b1, 8'h14, 32'h0000_0002, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_1100},
    {1'b1, 8'h10, 32'h0000_0400, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'h0000_0500},
    {1'b0, 8'h14, 32'h0,         32'h0},
    {1'b1, 8'h40, 32'h0,         32'h0},
    {1'b0, 8'h40, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic get_tx(input int t, output logic [7:0] b, output logic ok);
    int n;
    n = 0; ok = 1'b1; b = '0;
    do begin @(negedge clk); n++; end while (txd !== 1'b0 && n < 5000);
    if (n >= 5000) begin ok = 1'b0; return; end
    repeat (t/2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (t) @(negedge clk);
      b[i] = txd;
    end
    repeat (t) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic meas_low(output int w);
    int n;
    n = 0; w = 0;
    do begin @(negedge clk); n++; end while (txd !== 1'b0 && n < 5000);
    if (n >= 5000) return;
    w = 1;
    forever begin
      @(negedge clk);
      if (txd !== 1'b0 || w > 5000) break;
      w++;
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input int t);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (t-1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic watch_high(input int n, input string req);
    logic seen_low;
    seen_low = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    check(req, {31'd0, seen_low}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        ok;
    int          w;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0; rxd = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check("R1 mode after reset", d, 32'h0);
    rd(8'h10, d); check("R1 status after reset", d, 32'h100);
    check("R1 txd after reset", {31'd0, txd}, 32'd1);

    // R2 and R3 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], d);
        check($sformatf("R2_R3 vector %0d", i), d, VEC[i][31:0]);
      end
    end

    // R4 / R6: queue while disabled, fifth write dropped
    wr(8'h40, 32'd1);
    for (int i = 1; i <= 5; i++) wr(8'h20, 32'(i * 16));
    rd(8'h10, d); check("R6 queue full flag", d, 32'h0600);
    watch_high(100, "R4 line high while disabled");
    wr(8'h08, 32'h8000);
    for (int i = 1; i <= 4; i++) begin
      get_tx(32, b, ok);
      check($sformatf("R6 queued byte %0d", i), {24'd0, b}, 32'(i * 16));
      check("R5 frame start/stop", {31'd0, ok}, 32'd1);
    end
    watch_high(200, "R6 dropped byte not sent");
    rd(8'h10, d); check("R6 empty after drain", d, 32'h0500);

    // R5 bit time and framing at divider 1
    wr(8'h20, 32'hA5);
    meas_low(w); check("R5 start bit width", 32'(w), 32'd32);
    repeat (400) @(negedge clk);
    wr(8'h20, 32'h3C);
    get_tx(32, b, ok);
    check("R5 frame data", {24'd0, b}, 32'h3C);
    check("R5 stop bit", {31'd0, ok}, 32'd1);
    repeat (40) @(negedge clk);

    // R9 break after current frame, self clearing
    wr(8'h40, 32'd0);
    wr(8'h20, 32'h81);
    wr(8'h18, 32'h0800);
    get_tx(16, b, ok);
    check("R9 frame before break", {24'd0, b}, 32'h81);
    meas_low(w); check("R9 break length", 32'(w), 32'd160);
    repeat (20) @(negedge clk);
    rd(8'h10, d); check("R9 break bit cleared", d, 32'h0500);

    // R7 receive and pop
    wr(8'h18, 32'h1000);
    send_rx(8'hC3, 16);
    rd(8'h10, d); check("R7 data ready", d & 32'h3, 32'h1);
    rd(8'h30, d); check("R7 received byte", d, 32'hC3);
    rd(8'h10, d); check("R7 ready cleared after pop", d & 32'h3, 32'h0);

    // R10 short start pulse rejected
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(8'h10, d); check("R10 glitch rejected", d & 32'h3, 32'h0);
    send_rx(8'h5A, 16);
    rd(8'h30, d); check("R10 receiver recovers", d, 32'h5A);

    // R11 receive disabled
    wr(8'h14, 32'h1000);
    send_rx(8'h99, 16);
    rd(8'h10, d); check("R11 frame ignored", d & 32'h3, 32'h0);
    wr(8'h18, 32'h1000);

    // R8 sticky overrun
    send_rx(8'h11, 16); send_rx(8'h22, 16); send_rx(8'h33, 16); send_rx(8'h44, 16);
    send_rx(8'h55, 16);
    rd(8'h10, d); check("R8 overrun set", d & 32'h3, 32'h3);
    send_rx(8'h66, 16);
    rd(8'h10, d); check("R8 overrun sticky", d & 32'h3, 32'h3);
    wr(8'h14, 32'h0002);
    for (int i = 1; i <= 4; i++) begin
      rd(8'h30, d); check($sformatf("R8 kept byte %0d", i), d, 32'(i * 17));
    end
    rd(8'h10, d); check("R8 no byte taken while overrun", d & 32'h3, 32'h0);
    send_rx(8'h77, 16);
    rd(8'h30, d); check("R8 reception resumes", d, 32'h77);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule